// File: doc/BRIEF.md
# Clock Root Configuration Register Bank

This block is a small memory-mapped register bank that holds the settings for one clock root generator: the source selector, the pre-divider, the counter mode and the M, N and D values of the fractional divider. Software never writes the live settings directly. Every write lands in a shadow copy. The live copy that drives the clock multiplexer and dividers changes only when software requests a commit.

A commit starts when software writes the command word with the update bit set. At that edge the bank takes a snapshot of all shadow registers. Exactly two clock cycles later it loads the snapshot into the live outputs in a single edge and clears the update bit. Software polls that bit to learn that the new settings are in force. Writes that arrive while a commit is pending still go into the shadow registers, but they wait for the next commit. Each shadow register has a dirty flag that shows it differs from what was last handed to a commit.

The command word also holds a root enable bit and a read-only root-off status bit. The status bit reports whether the clock output is running. The bus is a simple single-cycle interface: a write takes effect at the clock edge where it is presented, and read data is combinational on the same cycle.

Top module: `clk_root_cfg_bank`

## Requirements
- R1: After reset, every shadow and live field is zero, the command word reads 0x8000_0000 (only root-off, bit 31, set) and `root_on` is 0.
- R2: A write to the config (byte address 0x4), M (0x8), N (0xC) or D (0x10) register changes only the shadow copy. The live outputs stay unchanged until a commit. Reads return the shadow value.
- R3: Writing the command word (0x0) with bit 0 set raises the update bit. It reads 1 for the two cycles after that write edge and reads 0 from the second following edge on.
- R4: At the edge where the update bit clears, all live outputs take, together, the shadow values that were present at the update write edge.
- R5: A write to a shadow register sets its dirty flag in the command word: bit 4 for config, bit 5 for N, bit 6 for M, bit 7 for D. A commit clears every flag except those for registers written while the commit was pending.
- R6: A write to a shadow register while an update is pending, including one on the commit edge itself, is stored and read back. It is not part of the pending commit, it keeps its dirty flag, and it reaches the outputs at the next commit.
- R7: Writing the update bit again while an update is pending does not restart or extend the commit. The commit still happens two cycles after the first request.
- R8: Command bit 1 is a readable root enable. `root_on` and the inverted status bit 31 follow it one clock edge after it is written.
- R9: Writes to the command word cannot change the dirty flags, bit 31 or any unused bit. Unused bits of all registers read as zero. Config keeps only the pre-divider (bits DIV_W-1:0), the source select (bits 10:8) and the mode (bits 13:12). M, N and D keep bits MND_W-1:0.
- R10: Writes to any other address, including misaligned ones, change nothing, and reads of such addresses return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_sel | input | 1 | Bus access this cycle |
| bus_we | input | 1 | Access is a write |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, same cycle |
| act_div | output | DIV_W | Live pre-divider |
| act_src | output | 3 | Live source select |
| act_mode | output | 2 | Live counter mode (2 = dual edge) |
| act_m | output | MND_W | Live M value |
| act_n | output | MND_W | Live N value |
| act_d | output | MND_W | Live D value |
| root_on | output | 1 | Clock root output is running |

## Verification
The bench builds the bank with its default parameters: a 5-bit pre-divider, 8-bit M/N/D fields and a commit delay of two cycles. With these values, all-ones writes show exactly which bits are kept, from bit 4 up to bit 13 of config and above bit 7 of the M, N and D registers. The short commit window also lets a directed sequence place a shadow write on each cycle of a pending update, including the commit edge itself, and place a second update request inside the window.

// File: rtl/clk_root_cfg_bank.sv
module clk_root_cfg_bank #(
  parameter int DIV_W      = 5,
  parameter int MND_W      = 8,
  parameter int COMMIT_CYC = 2,
  parameter int ADDR_W     = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [DIV_W-1:0]  act_div,
  output logic [2:0]        act_src,
  output logic [1:0]        act_mode,
  output logic [MND_W-1:0]  act_m,
  output logic [MND_W-1:0]  act_n,
  output logic [MND_W-1:0]  act_d,
  output logic              root_on
);

  localparam int CNT_W = (COMMIT_CYC > 1) ? $clog2(COMMIT_CYC) : 1;
  localparam int AGE_W = $clog2(COMMIT_CYC + 2);
  localparam logic [ADDR_W-1:0] A_CMD = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_CFG = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_M   = ADDR_W'(8);
  localparam logic [ADDR_W-1:0] A_N   = ADDR_W'(12);
  localparam logic [ADDR_W-1:0] A_D   = ADDR_W'(16);

  // dirty flag order: 0 config, 1 N, 2 M, 3 D (command bits 4..7)
  logic wr, wr_cmd, wr_cfg, wr_m, wr_n, wr_d;
  logic [3:0] wr_sh;
  assign wr     = bus_sel & bus_we;
  assign wr_cmd = wr && (bus_addr == A_CMD);
  assign wr_cfg = wr && (bus_addr == A_CFG);
  assign wr_m   = wr && (bus_addr == A_M);
  assign wr_n   = wr && (bus_addr == A_N);
  assign wr_d   = wr && (bus_addr == A_D);
  assign wr_sh  = {wr_d, wr_m, wr_n, wr_cfg};

  logic unused_wdata;
  assign unused_wdata = &{1'b0, bus_wdata};

  logic [DIV_W-1:0] sh_div, sn_div;
  logic [2:0]       sh_src, sn_src;
  logic [1:0]       sh_mode, sn_mode;
  logic [MND_W-1:0] sh_m, sh_n, sh_d, sn_m, sn_n, sn_d;

  logic             upd_q, en_q, on_q;
  logic [CNT_W-1:0] cnt_q;
  logic [3:0]       dirty_q, late_q;
  logic             start, commit;

  assign start  = wr_cmd & bus_wdata[0] & ~upd_q;
  assign commit = upd_q && (cnt_q == CNT_W'(COMMIT_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_div <= '0; sh_src <= '0; sh_mode <= '0;
      sh_m <= '0; sh_n <= '0; sh_d <= '0;
    end else begin
      if (wr_cfg) begin
        sh_div  <= bus_wdata[DIV_W-1:0];
        sh_src  <= bus_wdata[10:8];
        sh_mode <= bus_wdata[13:12];
      end
      if (wr_m) sh_m <= bus_wdata[MND_W-1:0];
      if (wr_n) sh_n <= bus_wdata[MND_W-1:0];
      if (wr_d) sh_d <= bus_wdata[MND_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sn_div <= '0; sn_src <= '0; sn_mode <= '0;
      sn_m <= '0; sn_n <= '0; sn_d <= '0;
    end else if (start) begin
      sn_div <= sh_div; sn_src <= sh_src; sn_mode <= sh_mode;
      sn_m <= sh_m; sn_n <= sh_n; sn_d <= sh_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_div <= '0; act_src <= '0; act_mode <= '0;
      act_m <= '0; act_n <= '0; act_d <= '0;
    end else if (commit) begin
      act_div <= sn_div; act_src <= sn_src; act_mode <= sn_mode;
      act_m <= sn_m; act_n <= sn_n; act_d <= sn_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upd_q <= 1'b0;
      cnt_q <= '0;
    end else if (start) begin
      upd_q <= 1'b1;
      cnt_q <= '0;
    end else if (commit) begin
      upd_q <= 1'b0;
    end else if (upd_q) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dirty_q <= '0;
      late_q  <= '0;
    end else begin
      for (int i = 0; i < 4; i++) begin
        if (commit) begin
          dirty_q[i] <= late_q[i] | wr_sh[i];
          late_q[i]  <= 1'b0;
        end else begin
          dirty_q[i] <= dirty_q[i] | wr_sh[i];
          late_q[i]  <= late_q[i] | (wr_sh[i] & upd_q);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0;
      on_q <= 1'b0;
    end else begin
      if (wr_cmd) en_q <= bus_wdata[1];
      on_q <= en_q;
    end
  end

  assign root_on = on_q;

  always_comb begin
    bus_rdata = '0;
    if (bus_sel) begin
      case (bus_addr)
        A_CMD: bus_rdata = {~on_q, 23'd0, dirty_q, 2'b00, en_q, upd_q};
        A_CFG: bus_rdata = 32'(sh_div) | (32'(sh_src) << 8) | (32'(sh_mode) << 12);
        A_M:   bus_rdata = 32'(sh_m);
        A_N:   bus_rdata = 32'(sh_n);
        A_D:   bus_rdata = 32'(sh_d);
        default: bus_rdata = '0;
      endcase
    end
  end

  logic [AGE_W-1:0] age_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age_q <= '0;
    else        age_q <= upd_q ? age_q + 1'b1 : '0;
  end

  AST_UPD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ((COMMIT_CYC >= 2) && $rose(upd_q)) |=> upd_q); // R3
  AST_UPD_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    upd_q |-> (age_q < AGE_W'(COMMIT_CYC))); // R3
  AST_ACT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(upd_q) |-> $stable({act_div, act_src, act_mode, act_m, act_n, act_d})); // R2
  AST_DIRTY_SET: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cfg |=> dirty_q[0]); // R5
  AST_ROOT_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    en_q |=> root_on); // R8

endmodule

// File: tb/clk_root_cfg_bank_tb.sv
module clk_root_cfg_bank_tb_top;
  localparam int DIV_W = 5, MND_W = 8, COMMIT_CYC = 2, ADDR_W = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_we = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [DIV_W-1:0] act_div;
  logic [2:0] act_src;
  logic [1:0] act_mode;
  logic [MND_W-1:0] act_m, act_n, act_d;
  logic root_on;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  clk_root_cfg_bank #(.DIV_W(DIV_W), .MND_W(MND_W), .COMMIT_CYC(COMMIT_CYC), .ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .act_div(act_div), .act_src(act_src),
    .act_mode(act_mode), .act_m(act_m), .act_n(act_n), .act_d(act_d), .root_on(root_on));

  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] actual, input logic [31:0] expected);
    checks++;
    if (actual !== expected) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", tag, actual, expected);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [ADDR_W-1:0] a, input logic [31:0] e);
    logic [31:0] v;
    rd(a, v);
    chk(tag, v, e);
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  function automatic logic [31:0] live_cfg();
    return 32'(act_div) | (32'(act_src) << 8) | (32'(act_mode) << 12);
  endfunction

  task automatic t_reset();
    rd_chk("R1 cmd after reset", 5'h00, 32'h8000_0000);
    rd_chk("R1 cfg after reset", 5'h04, 32'h0);
    rd_chk("R1 m after reset", 5'h08, 32'h0);
    chk("R1 live after reset", {live_cfg()[15:0], act_m, act_n, act_d, 7'd0, root_on}, 32'h0);
  endtask

  task automatic t_shadow();
    wr(5'h04, 32'hFFFF_FFFF);
    wr(5'h08, 32'hFFFF_FFAB);
    wr(5'h0C, 32'h0001_2345);
    wr(5'h10, 32'hFFFF_FF0F);
    rd_chk("R9 cfg mask", 5'h04, 32'h0000_371F);
    rd_chk("R9 m mask", 5'h08, 32'h0000_00AB);
    rd_chk("R2 n shadow", 5'h0C, 32'h0000_0045);
    rd_chk("R2 d shadow", 5'h10, 32'h0000_000F);
    chk("R2 live unchanged", {live_cfg()[15:0], act_m, act_n}, 32'h0);
    rd_chk("R5 all dirty", 5'h00, 32'h8000_00F0);
    wr(5'h14, 32'hFFFF_FFFF);
    wr(5'h06, 32'h0000_0000);
    rd_chk("R10 unmapped reads zero", 5'h14, 32'h0);
    rd_chk("R10 cfg untouched", 5'h04, 32'h0000_371F);
    rd_chk("R10 cmd untouched", 5'h00, 32'h8000_00F0);
  endtask

  task automatic t_commit();
    wr(5'h00, 32'h1);
    rd_chk("R3 update set", 5'h00, 32'h8000_00F1);
    chk("R2 live before commit", live_cfg(), 32'h0);
    step();
    rd_chk("R3 update still set", 5'h00, 32'h8000_00F1);
    chk("R3 live before commit 2", {24'd0, act_m}, 32'h0);
    step();
    rd_chk("R3 R5 update and dirty cleared", 5'h00, 32'h8000_0000);
    chk("R4 live cfg", live_cfg(), 32'h0000_371F);
    chk("R4 live mnd", {8'd0, act_m, act_n, act_d}, 32'h00AB_450F);
  endtask

  task automatic t_root();
    wr(5'h00, 32'h2);
    rd_chk("R8 enable read, still off", 5'h00, 32'h8000_0002);
    chk("R8 root_on lags", {31'd0, root_on}, 32'h0);
    step();
    rd_chk("R8 root running", 5'h00, 32'h0000_0002);
    chk("R8 root_on high", {31'd0, root_on}, 32'h1);
    wr(5'h00, 32'hFFFF_FFF2);
    rd_chk("R9 read-only bits", 5'h00, 32'h0000_0002);
    wr(5'h00, 32'h0);
    rd_chk("R8 disable lags", 5'h00, 32'h0000_0000);
    step();
    rd_chk("R8 root off", 5'h00, 32'h8000_0000);
    chk("R8 root_on low", {31'd0, root_on}, 32'h0);
  endtask

  task automatic t_pending();
    wr(5'h04, 32'h0000_2105);
    wr(5'h00, 32'h1);
    wr(5'h08, 32'h0000_0033);
    rd_chk("R6 pending write stored", 5'h08, 32'h0000_0033);
    rd_chk("R6 dirty while pending", 5'h00, 32'h8000_0051);
    step();
    rd_chk("R6 late dirty kept", 5'h00, 32'h8000_0040);
    chk("R6 late write excluded", {24'd0, act_m}, 32'h0000_00AB);
    chk("R4 cfg committed", live_cfg(), 32'h0000_2105);
    wr(5'h00, 32'h1);
    step();
    step();
    chk("R6 late write next commit", {24'd0, act_m}, 32'h0000_0033);
    rd_chk("R5 dirty cleared", 5'h00, 32'h8000_0000);
    wr(5'h00, 32'h1);
    step();
    wr(5'h0C, 32'h0000_0077);
    rd_chk("R6 write on commit edge dirty", 5'h00, 32'h8000_0020);
    chk("R6 commit-edge write excluded", {24'd0, act_n}, 32'h0000_0045);
  endtask

  task automatic t_retrigger();
    wr(5'h00, 32'h1);
    wr(5'h00, 32'h1);
    rd_chk("R7 pending after second request", 5'h00, 32'h8000_0021);
    step();
    rd_chk("R7 commit not extended", 5'h00, 32'h8000_0000);
    chk("R7 value committed", {24'd0, act_n}, 32'h0000_0077);
    step();
    rd_chk("R7 no second commit", 5'h00, 32'h8000_0000);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", checks, -1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_shadow();
    t_commit();
    t_root();
    t_pending();
    t_retrigger();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule